// File: doc/BRIEF.md
# Host Command Mailbox Channel

This block is a byte-wide mailbox between a host I/O bus and an on-chip controller. It answers at two host addresses: a data port at a base address and a command port four above it. It holds one input byte from the host and one output byte for the host. It also keeps a status byte, which the host reads at the command port. The bus framing is done elsewhere. This block sees single-cycle read and write strobes that carry an address and a byte.

The device side reads the input byte and writes the result byte. It also raises and drops a busy flag around each command and can flush a pending output byte. In command-channel mode, which is the default, the block protects the controller from a host that does not follow the protocol. A data-port write is thrown away, and so is a command that arrives while a previous command is still busy. In both cases the input-full flag is cleared and no new event is raised. Setting the parameter `CMD_CHANNEL` to 0 gives a plain mailbox that accepts every write and lets the device drive the burst flag.

A bus reset pulse clears input-full, so the next host write raises a fresh event.

Top module: `hmbx_channel`

## Requirements
- R1: After reset, every bit of the status byte is 0 and `in_evt` is 0.
- R2: A host write to the command port (base + 4) that is not dropped latches the byte, sets input-full (status bit 1) and sets the command flag (status bit 3). `in_evt` is high for exactly the one cycle after that write.
- R3: A device read strobe (`dev_in_rd`) sees the latched input byte on `dev_in_data` and clears input-full.
- R4: A device output write sets output-full (status bit 0). A host read of the data port (base) returns the output byte and clears output-full. If a device write and a host data read happen in the same cycle, the read returns the previous byte and output-full stays 1.
- R5: A host read of the command port returns the status byte with busy in bit 7, burst in bit 4, command flag in bit 3, input-full in bit 1, output-full in bit 0 and 0 in bits 6, 5 and 2. The read changes no state.
- R6: In command-channel mode, these writes are dropped: any data-port write, and any command-port write while busy is set. A dropped write clears input-full, leaves the input byte and the command flag unchanged, and raises no `in_evt`.
- R7: `dev_busy_set` sets busy (status bit 7). `dev_busy_clr` clears busy only if the device has written an output byte since busy was last set. Otherwise it has no effect.
- R8: In command-channel mode the burst bit (status bit 4) stays 0 even when `dev_burst_set` is asserted.
- R9: `dev_obf_clr` clears output-full. A device output write in the same cycle takes priority and leaves output-full set.
- R10: A `bus_rst` pulse clears input-full. A host write in the same cycle is not latched and raises no `in_evt`.
- R11: A host access to any address other than the two ports has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the cycle of `host_rd` |
| bus_rst | input | 1 | Host bus reset pulse |
| dev_in_rd | input | 1 | Device read of the input byte |
| dev_in_data | output | 8 | Latched input byte |
| dev_out_wr | input | 1 | Device write of the output byte |
| dev_out_data | input | 8 | Output byte from the device |
| dev_obf_clr | input | 1 | Device flush of output-full |
| dev_busy_set | input | 1 | Device sets busy |
| dev_busy_clr | input | 1 | Device request to clear busy |
| dev_burst_set | input | 1 | Device sets burst (mailbox mode only) |
| dev_burst_clr | input | 1 | Device clears burst |
| dev_status | output | 8 | Status byte as seen by the device |
| in_evt | output | 1 | One-cycle pulse after an accepted host write |

## Verification
The embedded properties hold on every cycle for these behaviours:
- an accepted command write always shows input-full, the command flag and the event pulse one cycle later;
- a dropped data-port write, a device read or a bus reset always leaves input-full clear;
- busy never falls before a result byte has been written;
- a device output write always sets output-full;
- burst stays low in command-channel mode.

Only the bench scenarios can show the data path. These scenarios check:
- which byte the host and the device read back;
- that a dropped write leaves the input byte unchanged;
- that a status read changes no state;
- that undecoded addresses have no effect;
- the same-cycle priorities between device writes, host reads, flushes and bus resets.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;

    typedef struct packed {
        logic       busy;
        logic [1:0] rsv_hi;
        logic       burst;
        logic       cmd;
        logic       rsv_lo;
        logic       ibf;
        logic       obf;
    } hmbx_status_t;

    typedef enum logic [1:0] {
        PORT_NONE = 2'd0,
        PORT_DATA = 2'd1,
        PORT_CMD  = 2'd2
    } hmbx_port_e;

    typedef struct packed {
        logic       wr;
        logic       rd;
        hmbx_port_e port;
    } hmbx_access_t;

    localparam hmbx_status_t STATUS_IDLE = '0;

    function automatic logic [7:0] status_byte(hmbx_status_t s);
        hmbx_status_t c;
        c        = s;
        c.rsv_hi = 2'b00;
        c.rsv_lo = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/hmbx_decode.sv
module hmbx_decode
    import hmbx_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int unsigned BASE_ADDR = 32'h0062,
    parameter int unsigned CMD_OFS   = 4
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    output hmbx_access_t      acc
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(BASE_ADDR + CMD_OFS);

    hmbx_port_e port;

    always_comb begin
        if (host_addr == DATA_ADDR)
            port = PORT_DATA;
        else if (host_addr == CMD_ADDR)
            port = PORT_CMD;
        else
            port = PORT_NONE;
        acc.port = port;
        acc.wr   = host_wr && (port != PORT_NONE);
        acc.rd   = host_rd && (port != PORT_NONE);
    end

    // R11: nothing is selected for an address outside the two ports
    always_comb begin
        if ((host_addr != DATA_ADDR) && (host_addr != CMD_ADDR))
            a_undecoded_r11: assert (!acc.wr && !acc.rd);
    end

endmodule

// File: rtl/hmbx_flags.sv
module hmbx_flags
    import hmbx_pkg::*;
#(
    parameter bit CMD_CHANNEL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  hmbx_access_t acc,
    input  logic         bus_rst,
    input  logic         dev_in_rd,
    input  logic         dev_out_wr,
    input  logic         dev_obf_clr,
    input  logic         dev_busy_set,
    input  logic         dev_busy_clr,
    input  logic         dev_burst_set,
    input  logic         dev_burst_clr,
    output hmbx_status_t status,
    output logic         accept,
    output logic         in_evt
);
    hmbx_status_t st;
    logic         res_written;
    logic         drop;
    logic         host_data_rd;
    logic         busy_release;

    always_comb begin
        drop = 1'b0;
        if (CMD_CHANNEL)
            drop = acc.wr && ((acc.port == PORT_DATA) || st.busy);
        accept       = acc.wr && !drop && !bus_rst;
        host_data_rd = acc.rd && (acc.port == PORT_DATA);
        busy_release = dev_busy_clr && res_written;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= STATUS_IDLE;
            res_written <= 1'b0;
            in_evt      <= 1'b0;
        end else begin
            in_evt <= accept;

            if (bus_rst)
                st.ibf <= 1'b0;
            else if (accept)
                st.ibf <= 1'b1;
            else if (drop || dev_in_rd)
                st.ibf <= 1'b0;

            if (accept)
                st.cmd <= (acc.port == PORT_CMD);

            if (dev_out_wr)
                st.obf <= 1'b1;
            else if (dev_obf_clr || host_data_rd)
                st.obf <= 1'b0;

            if (dev_busy_set)
                st.busy <= 1'b1;
            else if (busy_release)
                st.busy <= 1'b0;

            if (dev_busy_set)
                res_written <= 1'b0;
            else if (dev_out_wr)
                res_written <= 1'b1;

            if (!CMD_CHANNEL && dev_burst_set)
                st.burst <= 1'b1;
            else if (dev_burst_clr)
                st.burst <= 1'b0;
        end
    end

    assign status = st;

    // R2: an accepted command write shows up one cycle later
    p_cmd_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.port == PORT_CMD && !st.busy && !bus_rst)
        |=> (st.ibf && st.cmd && in_evt));

    // R3: a device read with no host write leaves input-full clear
    p_devrd_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (dev_in_rd && !acc.wr) |=> !st.ibf);

    // R4: a device write always leaves output-full set
    p_obf_set_r4: assert property (@(posedge clk) disable iff (rst)
        dev_out_wr |=> st.obf);

    // R7: busy cannot fall before a result byte is written
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (st.busy && !res_written) |=> st.busy);

    // R10: bus reset always leaves input-full clear
    p_busrst_r10: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> (!st.ibf && !in_evt));

    generate
        if (CMD_CHANNEL) begin : g_cmd_checks
            // R6: a data-port write never leaves input-full set
            p_data_drop_r6: assert property (@(posedge clk) disable iff (rst)
                (acc.wr && acc.port == PORT_DATA) |=> (!st.ibf && !in_evt));
            // R8: burst stays low
            p_burst_low_r8: assert property (@(posedge clk) disable iff (rst)
                !st.burst);
        end
    endgenerate

endmodule

// File: rtl/hmbx_channel.sv
module hmbx_channel
    import hmbx_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int unsigned BASE_ADDR   = 32'h0062,
    parameter int unsigned CMD_OFS     = 4,
    parameter bit          CMD_CHANNEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              bus_rst,
    input  logic              dev_in_rd,
    output logic [7:0]        dev_in_data,
    input  logic              dev_out_wr,
    input  logic [7:0]        dev_out_data,
    input  logic              dev_obf_clr,
    input  logic              dev_busy_set,
    input  logic              dev_busy_clr,
    input  logic              dev_burst_set,
    input  logic              dev_burst_clr,
    output logic [7:0]        dev_status,
    output logic              in_evt
);
    hmbx_access_t acc;
    hmbx_status_t status;
    logic         accept;
    logic [7:0]   in_byte;
    logic [7:0]   out_byte;

    hmbx_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .CMD_OFS   (CMD_OFS)
    ) u_decode (
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .acc       (acc)
    );

    hmbx_flags #(
        .CMD_CHANNEL (CMD_CHANNEL)
    ) u_flags (
        .clk           (clk),
        .rst           (rst),
        .acc           (acc),
        .bus_rst       (bus_rst),
        .dev_in_rd     (dev_in_rd),
        .dev_out_wr    (dev_out_wr),
        .dev_obf_clr   (dev_obf_clr),
        .dev_busy_set  (dev_busy_set),
        .dev_busy_clr  (dev_busy_clr),
        .dev_burst_set (dev_burst_set),
        .dev_burst_clr (dev_burst_clr),
        .status        (status),
        .accept        (accept),
        .in_evt        (in_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            in_byte  <= '0;
            out_byte <= '0;
        end else begin
            if (accept)
                in_byte <= host_wdata;
            if (dev_out_wr)
                out_byte <= dev_out_data;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (acc.rd) begin
            case (acc.port)
                PORT_DATA: host_rdata = out_byte;
                PORT_CMD:  host_rdata = status_byte(status);
                default:   host_rdata = '0;
            endcase
        end
    end

    assign dev_in_data = in_byte;
    assign dev_status  = status_byte(status);

    // R5: reserved status bits always read 0
    p_rsv_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (dev_status[6:5] == 2'b00) && (dev_status[2] == 1'b0));

endmodule

// File: tb/hmbx_channel_bench.sv
module hmbx_channel_bench;

    localparam int OP_HWR   = 0;
    localparam int OP_HRD   = 1;
    localparam int OP_DRD   = 2;
    localparam int OP_DWR   = 3;
    localparam int OP_BSET  = 4;
    localparam int OP_BCLR  = 5;
    localparam int OP_BURST = 6;
    localparam int OP_OCLR  = 7;

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        chk_rd;
        logic [7:0]  exp_rd;
        logic [7:0]  exp_st;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VEC [NVEC] = '{
        '{4'(OP_HWR),   16'h0066, 8'h80, 1'b0, 8'h00, 8'h0A}, // R2 command accepted
        '{4'(OP_DRD),   16'h0000, 8'h00, 1'b1, 8'h80, 8'h08}, // R3 device read
        '{4'(OP_BSET),  16'h0000, 8'h00, 1'b0, 8'h00, 8'h88}, // R7 busy set
        '{4'(OP_HWR),   16'h0062, 8'h11, 1'b0, 8'h00, 8'h88}, // R6 data write dropped
        '{4'(OP_HWR),   16'h0066, 8'h55, 1'b0, 8'h00, 8'h88}, // R6 overlap dropped
        '{4'(OP_BCLR),  16'h0000, 8'h00, 1'b0, 8'h00, 8'h88}, // R7 early clear ignored
        '{4'(OP_DWR),   16'h0000, 8'h3C, 1'b0, 8'h00, 8'h89}, // R4 result byte
        '{4'(OP_HRD),   16'h0066, 8'h00, 1'b1, 8'h89, 8'h89}, // R5 status read
        '{4'(OP_BCLR),  16'h0000, 8'h00, 1'b0, 8'h00, 8'h09}, // R7 clear honoured
        '{4'(OP_HRD),   16'h0062, 8'h00, 1'b1, 8'h3C, 8'h08}, // R4 data read
        '{4'(OP_HWR),   16'h0066, 8'h81, 1'b0, 8'h00, 8'h0A}, // R2
        '{4'(OP_HWR),   16'h0062, 8'h22, 1'b0, 8'h00, 8'h08}, // R6 drop clears ibf
        '{4'(OP_DRD),   16'h0000, 8'h00, 1'b1, 8'h81, 8'h08}, // R6 byte kept
        '{4'(OP_HWR),   16'h0064, 8'h99, 1'b0, 8'h00, 8'h08}, // R11 undecoded
        '{4'(OP_DRD),   16'h0000, 8'h00, 1'b1, 8'h81, 8'h08}, // R11 byte kept
        '{4'(OP_BURST), 16'h0000, 8'h00, 1'b0, 8'h00, 8'h08}, // R8 burst stays 0
        '{4'(OP_DWR),   16'h0000, 8'h77, 1'b0, 8'h00, 8'h09}, // R4
        '{4'(OP_OCLR),  16'h0000, 8'h00, 1'b0, 8'h00, 8'h08}, // R9 flush
        '{4'(OP_HRD),   16'h0062, 8'h00, 1'b1, 8'h77, 8'h08}  // R4 byte kept
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] host_addr;
    logic        host_wr, host_rd;
    logic [7:0]  host_wdata, host_rdata;
    logic        bus_rst;
    logic        dev_in_rd;
    logic [7:0]  dev_in_data;
    logic        dev_out_wr;
    logic [7:0]  dev_out_data;
    logic        dev_obf_clr, dev_busy_set, dev_busy_clr;
    logic        dev_burst_set, dev_burst_clr;
    logic [7:0]  dev_status;
    logic        in_evt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    hmbx_channel u_hmbx_channel (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .bus_rst(bus_rst), .dev_in_rd(dev_in_rd), .dev_in_data(dev_in_data),
        .dev_out_wr(dev_out_wr), .dev_out_data(dev_out_data),
        .dev_obf_clr(dev_obf_clr), .dev_busy_set(dev_busy_set),
        .dev_busy_clr(dev_busy_clr), .dev_burst_set(dev_burst_set),
        .dev_burst_clr(dev_burst_clr), .dev_status(dev_status), .in_evt(in_evt)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
        bus_rst = 0; dev_in_rd = 0; dev_out_wr = 0; dev_out_data = '0;
        dev_obf_clr = 0; dev_busy_set = 0; dev_busy_clr = 0;
        dev_burst_set = 0; dev_burst_clr = 0;
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check("R1 status after reset", dev_status, 8'h00);
        check("R1 in_evt after reset", {7'b0, in_evt}, 8'h00);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            case (int'(VEC[i].op))
                OP_HWR:   begin host_wr = 1; host_addr = VEC[i].addr; host_wdata = VEC[i].data; end
                OP_HRD:   begin host_rd = 1; host_addr = VEC[i].addr; end
                OP_DRD:   dev_in_rd = 1;
                OP_DWR:   begin dev_out_wr = 1; dev_out_data = VEC[i].data; end
                OP_BSET:  dev_busy_set = 1;
                OP_BCLR:  dev_busy_clr = 1;
                OP_BURST: dev_burst_set = 1;
                OP_OCLR:  dev_obf_clr = 1;
                default:  ;
            endcase
            #1;
            if (VEC[i].chk_rd) begin
                if (int'(VEC[i].op) == OP_HRD)
                    check($sformatf("vector %0d host read", i), host_rdata, VEC[i].exp_rd);
                else
                    check($sformatf("vector %0d device read", i), dev_in_data, VEC[i].exp_rd);
            end
            next_cycle();
            check($sformatf("vector %0d status", i), dev_status, VEC[i].exp_st);
        end

        // R2: event pulse lasts one cycle
        host_wr = 1; host_addr = 16'h0066; host_wdata = 8'h90;
        next_cycle();
        check("R2 in_evt after command write", {7'b0, in_evt}, 8'h01);
        check("R2 status after command write", dev_status, 8'h0A);
        next_cycle();
        check("R2 in_evt one cycle later", {7'b0, in_evt}, 8'h00);
        dev_in_rd = 1;
        next_cycle();

        // R6: dropped data write raises no event
        host_wr = 1; host_addr = 16'h0062; host_wdata = 8'h33;
        next_cycle();
        check("R6 no in_evt on dropped write", {7'b0, in_evt}, 8'h00);
        check("R6 input byte kept", dev_in_data, 8'h90);

        // R10: bus reset beats a same-cycle write, and clears input-full
        host_wr = 1; host_addr = 16'h0066; host_wdata = 8'hA5; bus_rst = 1;
        next_cycle();
        check("R10 ibf with write plus bus reset", {7'b0, dev_status[1]}, 8'h00);
        check("R10 no in_evt with bus reset", {7'b0, in_evt}, 8'h00);
        check("R10 byte not latched", dev_in_data, 8'h90);
        host_wr = 1; host_addr = 16'h0066; host_wdata = 8'h5A;
        next_cycle();
        check("R10 ibf before bus reset", {7'b0, dev_status[1]}, 8'h01);
        bus_rst = 1;
        next_cycle();
        check("R10 ibf after bus reset", {7'b0, dev_status[1]}, 8'h00);
        check("R3 input byte after bus reset", dev_in_data, 8'h5A);

        // R4: device write and host data read in the same cycle
        dev_out_wr = 1; dev_out_data = 8'h21;
        next_cycle();
        dev_out_wr = 1; dev_out_data = 8'h42; host_rd = 1; host_addr = 16'h0062;
        #1;
        check("R4 read during write returns old byte", host_rdata, 8'h21);
        next_cycle();
        check("R4 obf kept when write and read collide", {7'b0, dev_status[0]}, 8'h01);
        host_rd = 1; host_addr = 16'h0062;
        #1;
        check("R4 read returns new byte", host_rdata, 8'h42);
        next_cycle();
        check("R4 obf cleared by host read", {7'b0, dev_status[0]}, 8'h00);

        // R9: write beats flush, then flush alone
        dev_out_wr = 1; dev_out_data = 8'h10; dev_obf_clr = 1;
        next_cycle();
        check("R9 write wins over flush", {7'b0, dev_status[0]}, 8'h01);
        dev_obf_clr = 1;
        next_cycle();
        check("R9 flush clears obf", {7'b0, dev_status[0]}, 8'h00);

        // R5: status read at command port with nothing pending
        host_rd = 1; host_addr = 16'h0066;
        #1;
        check("R5 status via command port", host_rdata, 8'h08);
        next_cycle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule